// File: doc/BRIEF.md
# Block-Write Serial Register Slave

This block is a slave on a two-wire serial bus. It holds a small bank of 8-bit control registers that the rest of the chip reads as flat outputs. The bus lines are oversampled by a fast system clock rather than being used as a clock. A write transaction carries the device address, then two bytes whose values are ignored but which must still be sent, then data bytes. The first data byte lands in register 0, the next in register 1, and so on until the master ends the transfer. A read transaction always streams from register 0 upward.

The block has no register pointer that software can set. Each write and each read begins again at the lowest register. The highest register holds a fixed identification value that cannot be written. On a read, any byte past the bank comes back as 0xFF. On a write, any byte past the bank is acknowledged and then dropped. The registers take their default values only from the power-up reset.

Top module: `blkwr_reg_slave`

## Requirements
- R1: After reset, register 0 reads 0x00, registers 1 to 5 read 0xFF, and register 6 reads 0x59. Register i appears on regs_o[8i+7:8i].
- R2: The slave acknowledges (drives SDA low in the ninth clock) only address byte 0xD2 (write) or 0xD3 (read), which is the 7-bit address 0x69 plus the direction bit with 1 meaning read. Any other address gets no acknowledge and changes no register.
- R3: In a write, the two bytes after the address are acknowledged and discarded. The data bytes that follow are stored in registers 0, 1, 2 and onward in order, each one when its acknowledge is given. A transfer that ends after only those two bytes changes nothing.
- R4: Data written to register 6 is ignored, and data bytes beyond register 6 are acknowledged and discarded.
- R5: A read returns register 0 first, then each following register. Every byte past register 6 reads 0xFF.
- R6: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next start condition.
- R7: Bytes move most significant bit first in both directions. The slave changes its SDA drive only while SCL is low.
- R8: A repeated start in the middle of a transaction begins a new transaction, with its address phase and register index reset to zero.
- R9: A stop condition ends any transaction. A later write again needs its two discarded bytes before it stores data in register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample both bus lines |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| scl_i | input | 1 | Serial clock line from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge or a zero data bit) |
| regs_o | output | 56 | Register bank, register i in bits 8i+7 to 8i |

## Verification
The assertions take for granted that each SCL high and low phase lasts well beyond the three-cycle synchronizer and edge-detect latency. They also assume that the master never creates a start or stop while the slave is pulling SDA low. Under these assumptions, a drive change seen at the ports always falls inside an SCL-low phase. The stimulus holds each SCL phase for twenty system clocks and changes SDA only in the low phase, except for deliberate start and stop conditions. It issues a repeated start only after a write acknowledge has been released or after a read has been refused with a NACK.

// File: rtl/blkwr_pkg.sv
`timescale 1ns/1ps
// Shared types for the block-write register slave.
// Assumes 8-bit registers; the line event bundle is produced once per clk.
package blkwr_pkg;

    localparam int BYTE_W = 8;

    // Protocol phases of the slave engine
    typedef enum logic [2:0] {
        PH_IDLE,   // not addressed, ignore bus clocks
        PH_RECV,   // shifting a byte in on SCL rising edges
        PH_HOLD,   // eight bits taken, waiting for SCL low to answer
        PH_ACK,    // slave drives acknowledge during ninth clock
        PH_SEND,   // shifting a byte out, changed on SCL falling edges
        PH_MACK,   // waiting for master acknowledge on SCL rising edge
        PH_MWAIT   // master acknowledged, next byte loads on SCL fall
    } phase_e;

    // One-cycle events decoded from the synchronized bus lines
    typedef struct packed {
        logic sda;       // synchronized data line level
        logic scl_rise;  // SCL went low to high
        logic scl_fall;  // SCL went high to low
        logic start;     // SDA fell while SCL stayed high
        logic stop;      // SDA rose while SCL stayed high
    } line_ev_t;

endpackage

// File: rtl/tw_line_sync.sv
`timescale 1ns/1ps
// Brings SCL and SDA into the clk domain through a flop chain and decodes
// edges plus start and stop conditions.
// Assumes both lines idle high and each SCL phase outlasts STAGES+1 clocks.
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output blkwr_pkg::line_ev_t ev_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_pipe[TOP];
    assign sda_s = sda_pipe[TOP];

    generate
        if (STAGES == 1) begin : g_single
            // Capture the raw lines in a single stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_chain
            // Shift the raw lines through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    // Keep the previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode the one-cycle bus events
    always_comb begin
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_q;
        ev_o.scl_fall = ~scl_s & scl_q;
        ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/tw_regbank.sv
`timescale 1ns/1ps
// Register bank: NUM_REGS-1 writable bytes and a constant identification
// byte at the top index. Writes to the top index or beyond are dropped.
// Reads at or beyond NUM_REGS return all ones.
// Assumes at most one write per clk, indexed by the protocol engine.
module tw_regbank #(
    parameter int         NUM_REGS     = 7,
    parameter int         PTR_W        = 3,
    parameter logic [7:0] ID_VALUE     = 8'h59,
    parameter logic [7:0] REG0_DEFAULT = 8'h00,
    parameter logic [7:0] EN_DEFAULT   = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    localparam int               ID_IDX = NUM_REGS - 1;
    localparam logic [PTR_W-1:0] PAST   = PTR_W'(NUM_REGS);

    logic [7:0] bank [NUM_REGS];

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            if (i == ID_IDX) begin : g_id
                assign bank[i] = ID_VALUE;
            end else begin : g_rw
                localparam logic [7:0] DFLT = (i == 0) ? REG0_DEFAULT : EN_DEFAULT;
                // Hold one writable byte, loaded when its index is written
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        bank[i] <= DFLT;
                    end else if (wr_en && (wr_idx == PTR_W'(i))) begin
                        bank[i] <= wr_data;
                    end
                end
            end
            assign regs_flat[i*8 +: 8] = bank[i];
        end
    endgenerate

    // Select the byte to transmit, filling past the end with ones
    always_comb begin
        rd_data = 8'hFF;
        for (int k = 0; k < NUM_REGS; k++) begin
            if ((rd_idx < PAST) && (rd_idx == PTR_W'(k))) begin
                rd_data = bank[k];
            end
        end
    end

endmodule

// File: rtl/tw_proto_fsm.sv
`timescale 1ns/1ps
// Slave protocol engine: address match, two discarded header bytes on a
// write, streaming data to or from the bank starting at index 0.
// Assumes line events from tw_line_sync; drives SDA only through oe.
module tw_proto_fsm #(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 7,
    parameter int         PTR_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  blkwr_pkg::line_ev_t ev,
    input  logic [7:0]          rd_data,
    output logic                sda_oe,
    output logic                wr_en,
    output logic [PTR_W-1:0]    wr_idx,
    output logic [7:0]          wr_data,
    output logic [PTR_W-1:0]    rd_idx
);
    import blkwr_pkg::*;

    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);
    localparam logic [1:0]       HDR_DATA = 2'd3;

    phase_e           phase;
    logic [2:0]       bit_cnt;
    logic [7:0]       shreg;
    logic             is_read;
    logic [1:0]       hdr_cnt;   // 0 address, 1 command, 2 count, 3 data
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_next;
    logic             oe_q;

    // Advance the register index, holding once past the bank
    assign ptr_next = (ptr == PTR_END) ? ptr : ptr + PTR_W'(1);

    // A data byte commits when its acknowledge starts
    assign wr_en   = (phase == PH_HOLD) && ev.scl_fall && !is_read && (hdr_cnt == HDR_DATA);
    assign wr_idx  = ptr;
    assign wr_data = shreg;
    assign rd_idx  = ptr;
    assign sda_oe  = oe_q;

    // Step the protocol on bus events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= 3'd0;
            shreg   <= 8'd0;
            is_read <= 1'b0;
            hdr_cnt <= 2'd0;
            ptr     <= '0;
            oe_q    <= 1'b0;
        end else if (ev.start) begin
            phase   <= PH_RECV;
            bit_cnt <= 3'd0;
            hdr_cnt <= 2'd0;
            is_read <= 1'b0;
            ptr     <= '0;
            oe_q    <= 1'b0;
        end else if (ev.stop) begin
            phase <= PH_IDLE;
            oe_q  <= 1'b0;
        end else begin
            case (phase)
                PH_RECV: begin
                    if (ev.scl_rise) begin
                        shreg   <= {shreg[6:0], ev.sda};
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            phase <= PH_HOLD;
                        end
                    end
                end
                PH_HOLD: begin
                    if (ev.scl_fall) begin
                        if (hdr_cnt == 2'd0) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                oe_q    <= 1'b1;
                                is_read <= shreg[0];
                                hdr_cnt <= 2'd1;
                                phase   <= PH_ACK;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else begin
                            oe_q  <= 1'b1;
                            phase <= PH_ACK;
                            if (hdr_cnt == HDR_DATA) begin
                                ptr <= ptr_next;
                            end else begin
                                hdr_cnt <= hdr_cnt + 2'd1;
                            end
                        end
                    end
                end
                PH_ACK: begin
                    if (ev.scl_fall) begin
                        bit_cnt <= 3'd0;
                        if (is_read) begin
                            shreg <= rd_data;
                            oe_q  <= ~rd_data[7];
                            ptr   <= ptr_next;
                            phase <= PH_SEND;
                        end else begin
                            oe_q  <= 1'b0;
                            phase <= PH_RECV;
                        end
                    end
                end
                PH_SEND: begin
                    if (ev.scl_fall) begin
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            oe_q  <= 1'b0;
                            phase <= PH_MACK;
                        end else begin
                            shreg <= {shreg[6:0], 1'b0};
                            oe_q  <= ~shreg[6];
                        end
                    end
                end
                PH_MACK: begin
                    if (ev.scl_rise) begin
                        phase <= ev.sda ? PH_IDLE : PH_MWAIT;
                    end
                end
                PH_MWAIT: begin
                    if (ev.scl_fall) begin
                        shreg   <= rd_data;
                        oe_q    <= ~rd_data[7];
                        ptr     <= ptr_next;
                        bit_cnt <= 3'd0;
                        phase   <= PH_SEND;
                    end
                end
                default: begin
                    oe_q  <= 1'b0;
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/blkwr_reg_slave.sv
`timescale 1ns/1ps
// Top of the block-write register slave: line synchronizer, protocol
// engine and register bank. SDA is open drain: sda_oe_o=1 pulls low.
// Assumes rst_n is asserted only at power-up.
module blkwr_reg_slave #(
    parameter logic [6:0] DEV_ADDR     = 7'h69,
    parameter int         NUM_REGS     = 7,
    parameter logic [7:0] ID_VALUE     = 8'h59,
    parameter logic [7:0] REG0_DEFAULT = 8'h00,
    parameter logic [7:0] EN_DEFAULT   = 8'hFF,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int PTR_W = $clog2(NUM_REGS + 1);

    blkwr_pkg::line_ev_t ev;
    logic                wr_en;
    logic [PTR_W-1:0]    wr_idx;
    logic [7:0]          wr_data;
    logic [PTR_W-1:0]    rd_idx;
    logic [7:0]          rd_data;

    tw_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    tw_proto_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .rd_data (rd_data),
        .sda_oe  (sda_oe_o),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx)
    );

    tw_regbank #(
        .NUM_REGS     (NUM_REGS),
        .PTR_W        (PTR_W),
        .ID_VALUE     (ID_VALUE),
        .REG0_DEFAULT (REG0_DEFAULT),
        .EN_DEFAULT   (EN_DEFAULT)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

endmodule

// File: rtl/blkwr_reg_slave_chk.sv
`timescale 1ns/1ps
// Port-level checker for blkwr_reg_slave, attached by bind below.
// Assumes SCL phases longer than the synchronizer latency and no start or
// stop while the slave pulls SDA low.
module blkwr_reg_slave_chk #(
    parameter int         NUM_REGS     = 7,
    parameter logic [7:0] ID_VALUE     = 8'h59,
    parameter logic [7:0] REG0_DEFAULT = 8'h00,
    parameter logic [7:0] EN_DEFAULT   = 8'hFF
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] regs_o
);
    logic [NUM_REGS*8-1:0] regs_q;
    logic [NUM_REGS*8-1:0] dflt;
    logic [NUM_REGS-1:0]   byte_moved;

    // Remember the bank as it was one clock earlier
    always_ff @(posedge clk) begin
        regs_q <= regs_o;
    end

    // Build the default image and flag bytes that changed
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            dflt[i*8 +: 8]  = (i == NUM_REGS - 1) ? ID_VALUE :
                              ((i == 0) ? REG0_DEFAULT : EN_DEFAULT);
            byte_moved[i]   = (regs_o[i*8 +: 8] != regs_q[i*8 +: 8]);
        end
    end

    // R1
    reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs_o == dflt));

    // R7
    oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R3
    write_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> sda_oe_o);

    // R3
    one_byte_per_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(byte_moved));

endmodule

bind blkwr_reg_slave blkwr_reg_slave_chk #(
    .NUM_REGS     (NUM_REGS),
    .ID_VALUE     (ID_VALUE),
    .REG0_DEFAULT (REG0_DEFAULT),
    .EN_DEFAULT   (EN_DEFAULT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .regs_o   (regs_o)
);

// File: tb/tb_blkwr_reg_slave.sv
`timescale 1ns/1ps
module tb_blkwr_reg_slave;
    localparam int NREG = 7;

    logic            clk   = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl   = 1'b1;
    logic            m_sda = 1'b1;
    logic            sda_oe;
    logic [NREG*8-1:0] regs;
    wire             sda_line = m_sda & ~sda_oe;

    always #2 clk = ~clk;

    blkwr_reg_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    typedef struct {
        string tag;
        int    val;
    } item_t;

    item_t exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    model [NREG];

    // Driver side: queue an expected item
    task automatic push_exp(string tag, int val);
        item_t it;
        it.tag = tag;
        it.val = val;
        exp_q.push_back(it);
    endtask

    // Monitor side: pop the oldest expectation and compare
    task automatic sb_pop(int act);
        item_t it;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard empty: actual=%0h expected=none", act);
        end else begin
            it = exp_q.pop_front();
            if (it.val !== act) begin
                n_bad++;
                $display("FAIL %s: actual=%0h expected=%0h", it.tag, act, it.val);
            end
        end
    endtask

    task automatic half();
        repeat (20) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; half();
        scl   = 1'b1; half();
        m_sda = 1'b0; half();
        scl   = 1'b0; half();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; half();
        scl   = 1'b1; half();
        m_sda = 1'b1; half();
    endtask

    task automatic put_bit(logic b);
        m_sda = b; half();
        scl   = 1'b1; half();
        scl   = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; half();
        scl   = 1'b1; half();
        b     = sda_line;
        scl   = 1'b0;
    endtask

    // Send a byte and score whether the slave acknowledged (1 = ack)
    task automatic send_byte(logic [7:0] b, int exp_ack, string tag);
        logic a;
        push_exp(tag, exp_ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        sb_pop(a ? 0 : 1);
    endtask

    // Receive a byte and answer with ack (last=0) or nack (last=1)
    task automatic recv_byte(int exp_val, logic last, string tag);
        logic [7:0] v;
        push_exp(tag, exp_val);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(last);
        sb_pop(int'(v));
    endtask

    task automatic check_regs(string tag);
        for (int i = 0; i < NREG; i++) begin
            push_exp(tag, model[i]);
            sb_pop(int'(regs[i*8 +: 8]));
        end
    endtask

    // Model a data byte arriving at index idx
    task automatic model_write(int idx, int val);
        if (idx < NREG - 1) model[idx] = val;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic b;
        model[0] = 8'h00;
        for (int i = 1; i < NREG - 1; i++) model[i] = 8'hFF;
        model[NREG-1] = 8'h59;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_regs("R1 reset defaults");

        // R2: foreign address ignored
        bus_start();
        send_byte(8'hA0, 0, "R2 foreign address nack");
        send_byte(8'h12, 0, "R2 no ack after foreign address");
        bus_stop();
        check_regs("R2 regs untouched by foreign address");

        // R3: block write with two discarded bytes
        bus_start();
        send_byte(8'hD2, 1, "R2 write address ack");
        send_byte(8'h7E, 1, "R3 command byte ack");
        send_byte(8'h03, 1, "R3 count byte ack");
        send_byte(8'h5A, 1, "R3 data0 ack");
        send_byte(8'h11, 1, "R3 data1 ack");
        send_byte(8'h22, 1, "R3 data2 ack");
        bus_stop();
        model_write(0, 8'h5A); model_write(1, 8'h11); model_write(2, 8'h22);
        check_regs("R3 block write");

        // R3: header only changes nothing
        bus_start();
        send_byte(8'hD2, 1, "R2 write address ack");
        send_byte(8'hAA, 1, "R3 command byte ack");
        send_byte(8'hBB, 1, "R3 count byte ack");
        bus_stop();
        check_regs("R3 header-only write");

        // R5/R6: stream read, past end, nack then silence
        bus_start();
        send_byte(8'hD3, 1, "R2 read address ack");
        for (int i = 0; i < NREG; i++) recv_byte(model[i], 1'b0, "R5 read byte");
        recv_byte(8'hFF, 1'b1, "R5 read past end");
        half();
        push_exp("R6 SDA released after nack", 0);
        sb_pop(int'(sda_oe));
        begin
            logic [7:0] v;
            push_exp("R6 silent after nack", 8'hFF);
            for (int i = 7; i >= 0; i--) get_bit(v[i]);
            sb_pop(int'(v));
        end
        bus_stop();

        // R4: write runs past the bank
        bus_start();
        send_byte(8'hD2, 1, "R2 write address ack");
        send_byte(8'h00, 1, "R3 command byte ack");
        send_byte(8'h00, 1, "R3 count byte ack");
        for (int i = 0; i < 9; i++) begin
            send_byte(8'(8'hA0 + i), 1, "R4 data ack incl past end");
            model_write(i, 8'hA0 + i);
        end
        bus_stop();
        check_regs("R4 id protected and overrun dropped");

        // R8: repeated start restarts at index 0
        bus_start();
        send_byte(8'hD2, 1, "R2 write address ack");
        send_byte(8'h01, 1, "R3 command byte ack");
        send_byte(8'h02, 1, "R3 count byte ack");
        send_byte(8'h33, 1, "R8 data ack before restart");
        model_write(0, 8'h33);
        bus_start();
        send_byte(8'hD3, 1, "R8 read address after restart");
        recv_byte(model[0], 1'b0, "R8 first byte from index 0");
        recv_byte(model[1], 1'b1, "R8 second byte");
        bus_stop();

        // R9: stop mid header, then a fresh write needs both header bytes
        bus_start();
        send_byte(8'hD2, 1, "R2 write address ack");
        send_byte(8'h44, 1, "R9 command byte ack");
        bus_stop();
        check_regs("R9 aborted write changes nothing");
        bus_start();
        send_byte(8'hD2, 1, "R2 write address ack");
        send_byte(8'h55, 1, "R9 command byte ack");
        send_byte(8'h66, 1, "R9 count byte ack");
        send_byte(8'h01, 1, "R7 data ack");
        send_byte(8'h80, 1, "R7 data ack");
        bus_stop();
        model_write(0, 8'h01); model_write(1, 8'h80);
        check_regs("R7 R9 msb-first write after fresh header");

        // R7: msb-first read of asymmetric values
        bus_start();
        send_byte(8'hD3, 1, "R2 read address ack");
        recv_byte(8'h01, 1'b0, "R7 read 0x01 msb first");
        recv_byte(8'h80, 1'b1, "R7 read 0x80 msb first");
        bus_stop();

        half();
        summary();
        $finish;
    end

endmodule